// File: doc/BRIEF.md
# Width-Packing Card Data FIFO

This block sits between a CPU register port and a byte-serial card data path. It holds a 32-byte transmit FIFO and a 32-byte receive FIFO. The CPU reaches them through one read port and one write port, with access sizes of 1, 2 or 4 bytes. Each access moves as many bytes as the access width allows, and fewer if the FIFO runs empty or full. Bytes are packed and unpacked starting from the most significant lane of the access.

A transfer starts with a single pulse that carries a direction, a block count and a block length. The block loads their product into a byte counter, and each byte that crosses the card interface decrements it. When the counter reaches zero the transfer goes inactive and the completion flags are raised. The card side is a plain valid/ready byte stream in each direction. Service request bits tell the CPU, or a DMA engine, when the FIFOs need attention.

Top module: `card_data_fifo`

## Requirements
- R1: Each FIFO holds at most 32 bytes. A CPU write to a full TX FIFO stores nothing, and `cardRxReady` stays low while the RX FIFO holds 32 bytes.
- R2: A `xferStart` pulse does five things: it loads the remaining count with `blkCount * blkLen`, empties both FIFOs, clears both request bits and both done flags, and latches `dirWrite`. The transfer is active from the next cycle only if the product is nonzero.
- R3: A CPU read of size code `cpuSize` (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, N bytes in total) pops up to N bytes. The first byte popped appears on lane N-1 (bits 8N-1:8N-8), the next on lane N-2, and so on. The read stops when the FIFO empties, and any lane that is unfilled or outside the access reads as zero. `cpuRdData` is valid in the same cycle as `cpuRdEn`.
- R4: A CPU write of N bytes pushes lane N-1 first, then the lanes below it. It stops once the TX FIFO holds 32 bytes, and the remaining lanes are dropped.
- R5: In a write transfer, `cardTxValid` is high while bytes remain and the TX FIFO is not empty. `cardTxData` presents the oldest byte, and each handshake removes that byte and decrements the remaining count.
- R6: In a read transfer, `cardRxReady` is high while bytes remain and the RX FIFO holds fewer than 32 bytes. Each accepted byte is stored in order, decrements the count and sets `rxReq`.
- R7: After every cycle that leaves a write transfer active, `txReq` is 1, unless that cycle carried a CPU TX write. A CPU TX write clears `txReq`, and so does the end of the transfer.
- R8: A CPU RX read clears `rxReq`. If a byte arrives from the card in the same cycle, the request stays set.
- R9: When the remaining count reaches zero, the transfer goes inactive and `dataDone` is set. `progDone` is set as well when the transfer is a write. A start with a zero product completes at once.
- R10: A `txFlush` pulse empties the TX FIFO. A CPU write in the same cycle is discarded.
- R11: A `clkStop` pulse ends the transfer without setting the done flags. Card traffic stops in that same cycle, and the contents of both FIFOs are kept.
- R12: The direction latched at start selects the card path. A read transfer never raises `cardTxValid`, and a write transfer never raises `cardRxReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| xferStart | input | 1 | Start pulse, issued when a data command's response completes |
| dirWrite | input | 1 | Transfer direction at start: 1 = to card, 0 = from card |
| blkCount | input | 16 | Number of blocks |
| blkLen | input | 12 | Bytes per block |
| clkStop | input | 1 | Abort pulse (card clock stopped) |
| txFlush | input | 1 | Discard the TX FIFO contents |
| cpuRdEn | input | 1 | CPU read of the RX port |
| cpuWrEn | input | 1 | CPU write of the TX port |
| cpuSize | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| cpuWrData | input | 32 | CPU write data |
| cpuRdData | output | 32 | CPU read data, combinational |
| cardTxData | output | 8 | Byte toward the card |
| cardTxValid | output | 1 | TX byte valid |
| cardTxReady | input | 1 | Card accepts TX byte |
| cardRxData | input | 8 | Byte from the card |
| cardRxValid | input | 1 | RX byte valid |
| cardRxReady | output | 1 | Block accepts RX byte |
| xferActive | output | 1 | Transfer in progress |
| txReq | output | 1 | TX FIFO service request |
| rxReq | output | 1 | RX FIFO service request |
| dataDone | output | 1 | Transfer complete |
| progDone | output | 1 | Write transfer complete |

## Verification
The assertions check the per-cycle invariants on every cycle:
- FIFO occupancy never exceeds 32, and the RX level grows by at most one byte per cycle.
- The card handshake signals are gated by the active transfer, by FIFO occupancy and by an abort.
- A received byte always leaves `rxReq` set, and a CPU TX write always leaves `txReq` clear.
- `progDone` implies `dataDone`, and a transfer that ends without an abort or a restart always sets `dataDone`.

Only the bench scenarios can show the behaviour that depends on data:
- lane ordering of packed reads and writes for every access size and partial occupancy;
- byte order across the card interface;
- exact completion counts;
- flush and abort results, checked by comparing against a byte-queue model.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int BYTE_W = 8;

  // Strobes from control into the datapath.
  typedef struct packed {
    logic txClr;   // empty the TX FIFO
    logic rxClr;   // empty the RX FIFO
    logic txPop;   // a byte left toward the card
    logic rxPush;  // a byte arrived from the card
  } cdf_strobe_t;
endpackage

// File: rtl/cdf_byte_fifo.sv
module cdf_byte_fifo #(
  parameter int DEPTH = 32,
  parameter int PUSH_LANES = 4,
  parameter int POP_LANES = 1,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1),
  localparam int UW = $clog2(PUSH_LANES + 1),
  localparam int OW = $clog2(POP_LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        clr,
  input  logic [UW-1:0]               pushCnt,
  input  logic [PUSH_LANES-1:0][7:0]  pushData,
  input  logic [OW-1:0]               popCnt,
  output logic [POP_LANES-1:0][7:0]   peekData,
  output logic [LW-1:0]               level
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] rdPtr;
  logic [PW-1:0] wrPtr;

  // Element i of pushData is stored i places after the write pointer.
  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_LANES; i++) begin
      if (!clr && (i < int'(pushCnt))) begin
        mem[wrPtr + PW'(i)] <= pushData[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || clr) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      rdPtr <= rdPtr + PW'(popCnt);
      wrPtr <= wrPtr + PW'(pushCnt);
      level <= level + LW'(pushCnt) - LW'(popCnt);
    end
  end

  for (genvar g = 0; g < POP_LANES; g++) begin : g_peek
    assign peekData[g] = mem[rdPtr + PW'(g)];
  end
endmodule

// File: rtl/cdf_datapath.sv
module cdf_datapath import cdf_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int LW = $clog2(DEPTH + 1),
  localparam int NW = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cdf_strobe_t           st,
  input  logic                  cpuRdEn,
  input  logic                  cpuWrEn,
  input  logic [1:0]            cpuSize,
  input  logic [8*LANES-1:0]    cpuWrData,
  output logic [8*LANES-1:0]    cpuRdData,
  input  logic [7:0]            cardRxData,
  output logic [7:0]            cardTxData,
  output logic [LW-1:0]         txLevel,
  output logic [LW-1:0]         rxLevel
);
  int                     accLanes;
  logic [NW-1:0]          txPushCnt;
  logic [NW-1:0]          rxPopCnt;
  logic [LANES-1:0][7:0]  txPushData;
  logic [LANES-1:0][7:0]  rxPeek;
  logic [0:0][7:0]        txPeek;
  logic [0:0][7:0]        rxPushData;

  // Access width in bytes, capped at the bus width.
  always_comb begin
    accLanes = 1 << cpuSize;
    if (accLanes > LANES) accLanes = LANES;
  end

  // TX packing: the top lane of the access is pushed first.
  always_comb begin
    int space;
    int n;
    space = DEPTH - int'(txLevel);
    n = (accLanes < space) ? accLanes : space;
    txPushCnt = (cpuWrEn && !st.txClr) ? NW'(n) : '0;
    for (int i = 0; i < LANES; i++) begin
      int lane;
      lane = accLanes - 1 - i;
      txPushData[i] = (lane >= 0) ? cpuWrData[8*lane +: 8] : 8'h00;
    end
  end

  // RX unpacking: the i-th popped byte lands on lane accLanes-1-i.
  always_comb begin
    int avail;
    int n;
    avail = int'(rxLevel);
    n = (accLanes < avail) ? accLanes : avail;
    rxPopCnt = cpuRdEn ? NW'(n) : '0;
    cpuRdData = '0;
    for (int j = 0; j < LANES; j++) begin
      int idx;
      idx = accLanes - 1 - j;
      if (j < accLanes && idx < int'(rxPopCnt)) begin
        cpuRdData[8*j +: 8] = rxPeek[idx];
      end
    end
  end

  assign rxPushData[0] = cardRxData;
  assign cardTxData    = txPeek[0];

  cdf_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(LANES), .POP_LANES(1)) u_txFifo (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (st.txClr),
    .pushCnt  (txPushCnt),
    .pushData (txPushData),
    .popCnt   (1'(st.txPop)),
    .peekData (txPeek),
    .level    (txLevel)
  );

  cdf_byte_fifo #(.DEPTH(DEPTH), .PUSH_LANES(1), .POP_LANES(LANES)) u_rxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .clr      (st.rxClr),
    .pushCnt  (1'(st.rxPush)),
    .pushData (rxPushData),
    .popCnt   (rxPopCnt),
    .peekData (rxPeek),
    .level    (rxLevel)
  );
endmodule

// File: rtl/cdf_ctrl.sv
module cdf_ctrl import cdf_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int BLKCNT_W = 16,
  parameter int BLKLEN_W = 12,
  localparam int CNT_W = BLKCNT_W + BLKLEN_W,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 xferStart,
  input  logic                 dirWrite,
  input  logic [BLKCNT_W-1:0]  blkCount,
  input  logic [BLKLEN_W-1:0]  blkLen,
  input  logic                 clkStop,
  input  logic                 txFlush,
  input  logic                 cpuRdEn,
  input  logic                 cpuWrEn,
  input  logic                 cardTxReady,
  input  logic                 cardRxValid,
  input  logic [LW-1:0]        txLevel,
  input  logic [LW-1:0]        rxLevel,
  output logic                 cardTxValid,
  output logic                 cardRxReady,
  output cdf_strobe_t          st,
  output logic                 xferActive,
  output logic                 txReq,
  output logic                 rxReq,
  output logic                 dataDone,
  output logic                 progDone
);
  logic             dirWr;
  logic [CNT_W-1:0] bytesLeft;
  logic [CNT_W-1:0] loadCnt;
  logic             moving;
  logic             byteMoved;
  logic             lastByte;
  logic             activeNext;

  assign loadCnt    = CNT_W'(blkCount) * CNT_W'(blkLen);
  assign moving     = xferActive && (bytesLeft != '0) && !clkStop && !xferStart;
  assign cardTxValid = moving && dirWr && (txLevel != '0);
  assign cardRxReady = moving && !dirWr && (rxLevel < LW'(DEPTH));

  assign st.txPop  = cardTxValid && cardTxReady;
  assign st.rxPush = cardRxReady && cardRxValid;
  assign st.txClr  = xferStart || txFlush;
  assign st.rxClr  = xferStart;

  assign byteMoved  = st.txPop || st.rxPush;
  assign lastByte   = byteMoved && (bytesLeft == CNT_W'(1));
  assign activeNext = xferActive && !lastByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferActive <= 1'b0;
      dirWr      <= 1'b0;
      bytesLeft  <= '0;
      dataDone   <= 1'b0;
      progDone   <= 1'b0;
      txReq      <= 1'b0;
      rxReq      <= 1'b0;
    end else if (xferStart) begin
      xferActive <= (loadCnt != '0);
      dirWr      <= dirWrite;
      bytesLeft  <= loadCnt;
      dataDone   <= (loadCnt == '0);
      progDone   <= (loadCnt == '0) && dirWrite;
      txReq      <= 1'b0;
      rxReq      <= 1'b0;
    end else if (clkStop) begin
      xferActive <= 1'b0;
      txReq      <= 1'b0;
      if (cpuRdEn) rxReq <= 1'b0;
    end else begin
      if (byteMoved) bytesLeft <= bytesLeft - CNT_W'(1);
      if (lastByte) begin
        xferActive <= 1'b0;
        dataDone   <= 1'b0 | 1'b1;
        progDone   <= dirWr;
      end
      txReq <= !cpuWrEn && activeNext && dirWr;
      if (st.rxPush)   rxReq <= 1'b1;
      else if (cpuRdEn) rxReq <= 1'b0;
    end
  end
endmodule

// File: rtl/card_data_fifo.sv
module card_data_fifo import cdf_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int BUS_BYTES = 4,
  parameter int BLKCNT_W = 16,
  parameter int BLKLEN_W = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    xferStart,
  input  logic                    dirWrite,
  input  logic [BLKCNT_W-1:0]     blkCount,
  input  logic [BLKLEN_W-1:0]     blkLen,
  input  logic                    clkStop,
  input  logic                    txFlush,
  input  logic                    cpuRdEn,
  input  logic                    cpuWrEn,
  input  logic [1:0]              cpuSize,
  input  logic [8*BUS_BYTES-1:0]  cpuWrData,
  output logic [8*BUS_BYTES-1:0]  cpuRdData,
  output logic [7:0]              cardTxData,
  output logic                    cardTxValid,
  input  logic                    cardTxReady,
  input  logic [7:0]              cardRxData,
  input  logic                    cardRxValid,
  output logic                    cardRxReady,
  output logic                    xferActive,
  output logic                    txReq,
  output logic                    rxReq,
  output logic                    dataDone,
  output logic                    progDone
);
  localparam int LW = $clog2(DEPTH + 1);

  cdf_strobe_t    st;
  logic [LW-1:0]  txLevel;
  logic [LW-1:0]  rxLevel;

  cdf_ctrl #(.DEPTH(DEPTH), .BLKCNT_W(BLKCNT_W), .BLKLEN_W(BLKLEN_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .xferStart   (xferStart),
    .dirWrite    (dirWrite),
    .blkCount    (blkCount),
    .blkLen      (blkLen),
    .clkStop     (clkStop),
    .txFlush     (txFlush),
    .cpuRdEn     (cpuRdEn),
    .cpuWrEn     (cpuWrEn),
    .cardTxReady (cardTxReady),
    .cardRxValid (cardRxValid),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .cardTxValid (cardTxValid),
    .cardRxReady (cardRxReady),
    .st          (st),
    .xferActive  (xferActive),
    .txReq       (txReq),
    .rxReq       (rxReq),
    .dataDone    (dataDone),
    .progDone    (progDone)
  );

  cdf_datapath #(.DEPTH(DEPTH), .LANES(BUS_BYTES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .cpuRdEn    (cpuRdEn),
    .cpuWrEn    (cpuWrEn),
    .cpuSize    (cpuSize),
    .cpuWrData  (cpuWrData),
    .cpuRdData  (cpuRdData),
    .cardRxData (cardRxData),
    .cardTxData (cardTxData),
    .txLevel    (txLevel),
    .rxLevel    (rxLevel)
  );
endmodule

// File: rtl/cdf_checker.sv
module cdf_checker #(
  parameter int DEPTH = 32,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          xferStart,
  input logic          clkStop,
  input logic          cpuWrEn,
  input logic          cardTxValid,
  input logic          cardRxValid,
  input logic          cardRxReady,
  input logic          xferActive,
  input logic          txReq,
  input logic          rxReq,
  input logic          dataDone,
  input logic          progDone,
  input logic [LW-1:0] txLevel,
  input logic [LW-1:0] rxLevel
);
  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(txLevel) <= DEPTH) && (int'(rxLevel) <= DEPTH));

  // R6
  rx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(rxLevel) <= int'($past(rxLevel)) + 1);

  // R5
  tx_valid_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardTxValid |-> (xferActive && txLevel != '0));

  // R6
  rx_ready_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    cardRxReady |-> (xferActive && int'(rxLevel) < DEPTH));

  // R6
  rx_req_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cardRxValid && cardRxReady) |=> rxReq);

  // R7
  tx_req_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuWrEn |=> !txReq);

  // R9
  prog_implies_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    progDone |-> dataDone);

  // R9
  end_flags_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(xferActive) && !$past(clkStop) && !$past(xferStart)) |-> dataDone);

  // R11
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkStop |-> (!cardTxValid && !cardRxReady));
endmodule

bind card_data_fifo cdf_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_card_data_fifo.sv
`timescale 1ns/1ps
module tb_card_data_fifo;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferStart = 1'b0;
  logic        dirWrite = 1'b0;
  logic [15:0] blkCount = '0;
  logic [11:0] blkLen = '0;
  logic        clkStop = 1'b0;
  logic        txFlush = 1'b0;
  logic        cpuRdEn = 1'b0;
  logic        cpuWrEn = 1'b0;
  logic [1:0]  cpuSize = '0;
  logic [31:0] cpuWrData = '0;
  logic [31:0] cpuRdData;
  logic [7:0]  cardTxData;
  logic        cardTxValid;
  logic        cardTxReady = 1'b0;
  logic [7:0]  cardRxData = '0;
  logic        cardRxValid = 1'b0;
  logic        cardRxReady;
  logic        xferActive, txReq, rxReq, dataDone, progDone;

  always #5 clk = ~clk;

  card_data_fifo dut (.*);

  int checks = 0;
  int fails  = 0;
  logic [7:0] mq [64];
  int mHead = 0;
  int mCnt  = 0;
  logic [7:0] rxSeed = 8'h30;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void mPush(logic [7:0] b);
    mq[(mHead + mCnt) % 64] = b;
    mCnt++;
  endfunction

  function automatic logic [7:0] mPop();
    logic [7:0] b;
    b = mq[mHead];
    mHead = (mHead + 1) % 64;
    mCnt--;
    return b;
  endfunction

  function automatic int lanesOf(logic [1:0] sz);
    return (sz >= 2) ? 4 : (1 << sz);
  endfunction

  task automatic startXfer(logic dir, int cnt, int len);
    @(negedge clk);
    xferStart = 1'b1; dirWrite = dir; blkCount = 16'(cnt); blkLen = 12'(len);
    @(posedge clk); #1;
    xferStart = 1'b0;
    mCnt = 0; mHead = 0;
  endtask

  task automatic rxDeliver(int n, output int acc);
    acc = 0;
    for (int k = 0; k < n; k++) begin
      logic rdy;
      @(negedge clk);
      cardRxValid = 1'b1; cardRxData = rxSeed;
      #1 rdy = cardRxReady;
      @(posedge clk); #1;
      cardRxValid = 1'b0;
      if (rdy) begin
        mPush(rxSeed);
        rxSeed = rxSeed + 8'd13;
        acc++;
      end
    end
  endtask

  task automatic cpuRead(logic [1:0] sz, string req);
    logic [31:0] got, exp;
    int n, k;
    @(negedge clk);
    cpuRdEn = 1'b1; cpuSize = sz;
    #1 got = cpuRdData;
    n = lanesOf(sz);
    k = (n < mCnt) ? n : mCnt;
    exp = '0;
    for (int i = 0; i < k; i++) exp[8*(n-1-i) +: 8] = mPop();
    @(posedge clk); #1;
    cpuRdEn = 1'b0;
    chk(req, $sformatf("rx read size %0d", sz), got, exp);
  endtask

  task automatic cpuWrite(logic [1:0] sz, logic [31:0] d);
    int n;
    n = lanesOf(sz);
    for (int i = 0; i < n; i++)
      if (mCnt < 32) mPush(d[8*(n-1-i) +: 8]);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuSize = sz; cpuWrData = d;
    @(posedge clk); #1;
    cpuWrEn = 1'b0;
  endtask

  task automatic txDrain(int cycles, string req, output int sent);
    sent = 0;
    for (int c = 0; c < cycles; c++) begin
      logic v;
      logic [7:0] d;
      @(negedge clk);
      cardTxReady = 1'b1;
      #1 v = cardTxValid; d = cardTxData;
      @(posedge clk); #1;
      if (v) begin
        chk(req, "tx byte order", {24'h0, d}, {24'h0, mPop()});
        sent++;
      end
    end
    cardTxReady = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    int acc;
    int sent;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // reset state (R2)
    chk("R2", "reset active", xferActive, 0);
    chk("R2", "reset flags", {txReq, rxReq, dataDone, progDone}, 0);
    chk("R5", "reset txValid", cardTxValid, 0);

    // ---- read direction: size x occupancy sweep
    startXfer(1'b0, 100, 100);
    chk("R2", "start active", xferActive, 1);
    chk("R2", "start rxReq", rxReq, 0);
    for (int p = 0; p < 6; p++) begin
      for (int sz = 0; sz < 4; sz++) begin
        rxDeliver(p, acc);
        chk("R6", "accepted", acc, p);
        chk("R6", "rxReq after receive", rxReq, (p > 0) ? 1 : 0);
        chk("R12", "no tx in read", cardTxValid, 0);
        cpuRead(2'(sz), "R3");
        chk("R8", "rxReq after read", rxReq, 0);
        while (mCnt > 0) cpuRead(2'd2, "R3");
      end
    end

    // RX full boundary
    rxDeliver(40, acc);
    chk("R1", "rx accepted to full", acc, 32);
    @(negedge clk); cardRxValid = 1'b1;
    #1 chk("R1", "rx ready at full", cardRxReady, 0);
    @(posedge clk); #1 cardRxValid = 1'b0;
    while (mCnt > 0) cpuRead(2'd3, "R3");

    // read and receive in same cycle: set wins
    rxDeliver(2, acc);
    @(negedge clk);
    cpuRdEn = 1'b1; cpuSize = 2'd0; cardRxValid = 1'b1; cardRxData = 8'hEE;
    #1 chk("R3", "read with arrival", cpuRdData, {24'h0, mq[mHead]});
    @(posedge clk); #1;
    cpuRdEn = 1'b0; cardRxValid = 1'b0;
    void'(mPop()); mPush(8'hEE);
    chk("R8", "rxReq set wins", rxReq, 1);
    while (mCnt > 0) cpuRead(2'd2, "R3");

    // read completion
    startXfer(1'b0, 2, 3);
    rxDeliver(5, acc);
    chk("R9", "not done early", {xferActive, dataDone}, 2'b10);
    rxDeliver(3, acc);
    chk("R9", "last accepted", acc, 1);
    chk("R9", "read done flags", {xferActive, dataDone, progDone}, 3'b010);
    cpuRead(2'd2, "R3");
    cpuRead(2'd1, "R3");
    cpuRead(2'd2, "R3");

    // ---- write direction
    startXfer(1'b1, 100, 100);
    chk("R7", "txReq after start", txReq, 0);
    @(negedge clk); cardRxValid = 1'b1;
    #1 chk("R12", "no rx in write", cardRxReady, 0);
    @(posedge clk); #1 cardRxValid = 1'b0;
    chk("R7", "txReq while remaining", txReq, 1);
    for (int sz = 0; sz < 4; sz++) begin
      cpuWrite(2'(sz), 32'hA1B2C3D4 + 32'(sz) * 32'h01010101);
      chk("R7", "txReq cleared by write", txReq, 0);
    end
    txDrain(14, "R4", sent);
    chk("R5", "tx sent count", sent, 11);
    chk("R7", "txReq back", txReq, 1);

    cpuWrite(2'd0, 32'h0000005A);
    for (int k = 0; k < 7; k++) cpuWrite(2'd2, 32'h10203040 + 32'(k));
    cpuWrite(2'd2, 32'hC0C1C2C3);
    chk("R1", "model full", mCnt, 32);
    cpuWrite(2'd2, 32'hDEADBEEF);
    txDrain(40, "R4", sent);
    chk("R1", "tx full count", sent, 32);
    chk("R5", "tx empty valid", cardTxValid, 0);

    // flush
    cpuWrite(2'd2, 32'h11223344);
    cpuWrite(2'd2, 32'h55667788);
    @(negedge clk); txFlush = 1'b1;
    @(posedge clk); #1 txFlush = 1'b0; mCnt = 0;
    txDrain(4, "R10", sent);
    chk("R10", "flush discards", sent, 0);
    @(negedge clk); txFlush = 1'b1; cpuWrEn = 1'b1; cpuSize = 2'd2; cpuWrData = 32'h99999999;
    @(posedge clk); #1 txFlush = 1'b0; cpuWrEn = 1'b0;
    txDrain(4, "R10", sent);
    chk("R10", "flush beats write", sent, 0);

    // write completion
    startXfer(1'b1, 1, 5);
    cpuWrite(2'd2, 32'hF0F1F2F3);
    cpuWrite(2'd2, 32'hF4F5F6F7);
    txDrain(12, "R5", sent);
    chk("R9", "write sent", sent, 5);
    chk("R9", "write done flags", {xferActive, dataDone, progDone}, 3'b011);
    chk("R7", "txReq after end", txReq, 0);

    // zero length
    startXfer(1'b1, 0, 7);
    chk("R9", "zero write", {xferActive, dataDone, progDone}, 3'b011);
    startXfer(1'b0, 5, 0);
    chk("R9", "zero read", {xferActive, dataDone, progDone}, 3'b010);

    // abort keeps contents
    startXfer(1'b0, 1, 100);
    rxDeliver(3, acc);
    @(negedge clk); clkStop = 1'b1;
    @(posedge clk); #1 clkStop = 1'b0;
    chk("R11", "abort flags", {xferActive, dataDone, progDone}, 3'b000);
    rxDeliver(2, acc);
    chk("R11", "no rx after abort", acc, 0);
    cpuRead(2'd2, "R11");

    // restart empties FIFOs
    startXfer(1'b0, 1, 100);
    rxDeliver(4, acc);
    startXfer(1'b0, 1, 100);
    chk("R2", "restart rxReq", rxReq, 0);
    cpuRead(2'd2, "R2");

    repeat (2) @(posedge clk);
    finishRun();
  end
endmodule